// File: doc/BRIEF.md
# Prioritized Trap and Exception Controller

This block sits beside the sequencer of a pipelined instruction unit and decides, once per clock, which exception the pipeline takes next. It weighs reset, bus faults and rejects, ALU condition outcomes, stack overflow flags, a prefetch fault and a sticky reschedule request against a fixed priority. It registers the chosen exception code, a pipeline-kill strobe and the byte address of the matching trap vector.

The block also keeps three pieces of sequencing state. The first is the micro-cycle counter of multi-cycle instructions: it clears when an instruction completes, holds while the pipe stalls, doubles on a taken micro-jump and otherwise counts up. The second is a sticky reschedule-request flag. The third is a trap-inhibit flag. The inhibit flag and the pending trap effect together decide whether the maskable exceptions may be taken. All outputs are registered and change on the rising clock edge.

Top module: `trap_exception_unit`

## Requirements
- R1: Exceptions are chosen in this order, highest first: `rstIn` high gives code 1; code 1 held last cycle gives code 2; a nonzero `busFault` gives code 3; `aluCondTrue` with `condEffect`=2 and `busReject` low gives code 4; `busReject` gives code 5; `aluCondTrue` with `condEffect`=3 gives code 6; a nonzero next cycle count gives code 0; then codes 7, 8, 9 and 10 as set out in R9 and R10; in all other cases code 0.
- R2: Codes 1 and 2 each clear the cycle counter and the reschedule flag, set the inhibit flag and raise `killPipe`. Code 2 follows code 1 on the first clock with `rstIn` low.
- R3: Codes 3, 4 and 6 clear the cycle counter and raise `killPipe`. Codes 3 and 4 also set the inhibit flag. Code 5 leaves `killPipe` low and does not clear the counter.
- R4: `trapAddr` = BPW*(BASE + WIDTH*(index + offset)). The defaults are BPW=4, BASE=64 and WIDTH=4. The index is 2 for codes 1 and 2, 8 for code 3, 16 for code 4, 3 for code 7, 4 for code 8, 5 for code 9 and 6 for code 10. The offset is `busFault` for code 3, `aluCondCode` for code 4, and zero otherwise.
- R5: Codes 5 and 6 drive `trapAddr` to zero.
- R6: The next count is 0 when `cycDone` is high. Otherwise it holds when `cycDelayed` is high, doubles when `aluCondTrue` is high with `condEffect`=1, and increments in all other cases, wrapping at CYC_W bits.
- R7: `reschedPending` is set by `reschedReq` or by `reschedCtl`=1 (set). It is cleared by `reschedCtl`=2 (clear) and otherwise holds.
- R8: `trapInhibit` is set by `trapEffNow`=2 (disable) or by `inhibitCtl`=1. It is cleared by `inhibitCtl`=2 or by `trapEffNow`=1 (enable) and otherwise holds. Traps are enabled when `trapEffPending`=1, or when `trapEffPending`≠2 and the next inhibit value is 0.
- R9: Code 7 is taken when the next reschedule flag is set and traps are enabled. Code 8 needs `iStackOvf`, traps enabled, and `pushPending` high or `popPending` low. Code 9 needs `eStackOvf` and traps enabled. Code 10 needs `fetchFault` only.
- R10: A current code of 7, 8, 9 or 10 is kept for one more cycle when `cycDelayed` is high, at its own priority slot.
- R11: Code 0 drives `trapAddr` to the stack-underflow vector (index 1, address 272 with default values).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstIn | input | 1 | Reset request, begins the two-phase reset |
| busFault | input | FAULT_W | Bus fault code, 0 means no fault |
| busReject | input | 1 | Bus rejected the current access |
| aluCondTrue | input | 1 | Selected ALU condition is true |
| condEffect | input | 2 | 0 none, 1 micro-jump, 2 macro trap, 3 macro jump |
| aluCondCode | input | COND_W | Selected ALU condition code |
| iStackOvf | input | 1 | Instruction-stack overflow |
| eStackOvf | input | 1 | Execution-stack overflow |
| pushPending | input | 1 | Instruction-stack push pending |
| popPending | input | 1 | Instruction-stack pop pending |
| fetchFault | input | 1 | Prefetch faulted |
| reschedReq | input | 1 | Reschedule request |
| reschedCtl | input | 2 | Status control for reschedule: 0 hold, 1 set, 2 clear |
| inhibitCtl | input | 2 | Status control for inhibit: 0 hold, 1 set, 2 clear |
| trapEffNow | input | 2 | Trap effect now applied: 0 none, 1 enable, 2 disable |
| trapEffPending | input | 2 | Trap effect pending: 0 none, 1 enable, 2 disable |
| cycDone | input | 1 | Current instruction finished this cycle |
| cycDelayed | input | 1 | Pipeline was stalled last cycle |
| excState | output | 4 | Registered exception code |
| killPipe | output | 1 | Pipeline-kill strobe |
| trapAddr | output | ADDR_W | Byte address of the trap vector |
| cycleCount | output | CYC_W | Micro-cycle counter |
| reschedPending | output | 1 | Sticky reschedule flag |
| trapInhibit | output | 1 | Trap-inhibit flag |

## Verification
On every cycle, the assertions check that the reset phases follow each other, that a kill always arrives with a zero cycle count, that reject and jump-flip always give a zero vector, that the reschedule and inhibit flags stay sticky, and that a stall freezes the counter. The full priority chain needs the bench's reference model and its scenarios. This covers rejects that mask condition traps, overflow gating by the enable and push/pop state, and exceptions held through stalls. Vector offsets taken from fault and condition codes are also shown only by those scenarios.

// File: rtl/trap_exc_pkg.sv
package trap_exc_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [3:0] {
    EXC_NONE = 4'd0, EXC_PRE_RST = 4'd1, EXC_RST = 4'd2, EXC_BUS_FAULT = 4'd3,
    EXC_COND_TRAP = 4'd4, EXC_BUS_REJECT = 4'd5, EXC_JUMP_FLIP = 4'd6,
    EXC_RESCHED = 4'd7, EXC_ISTK_OVF = 4'd8, EXC_ESTK_OVF = 4'd9,
    EXC_FETCH_FAULT = 4'd10
  } exc_e;

  localparam logic [1:0] CE_MICRO_JUMP = 2'd1;
  localparam logic [1:0] CE_MACRO_TRAP = 2'd2;
  localparam logic [1:0] CE_MACRO_JUMP = 2'd3;
  localparam logic [1:0] CTL_SET   = 2'd1;
  localparam logic [1:0] CTL_CLEAR = 2'd2;
  localparam logic [1:0] TE_ENABLE  = 2'd1;
  localparam logic [1:0] TE_DISABLE = 2'd2;

  typedef struct packed {
    logic             clrCycle;
    logic             vecZero;
    logic [IDX_W-1:0] vecIndex;
    logic [IDX_W-1:0] vecOffset;
  } dp_ctl_t;
endpackage

// File: rtl/trap_exc_ctl.sv
module trap_exc_ctl
  import trap_exc_pkg::*;
#(
  parameter int FAULT_W = 3,
  parameter int COND_W  = 4,
  parameter int IDX_RESET = 2, parameter int IDX_UNDERFLOW = 1,
  parameter int IDX_BUS0 = 8,  parameter int IDX_COND0 = 16,
  parameter int IDX_RESCHED = 3, parameter int IDX_ISTK = 4,
  parameter int IDX_ESTK = 5,  parameter int IDX_FETCH = 6
) (
  input  logic               clk,
  input  logic               rstIn,
  input  logic [FAULT_W-1:0] busFault,
  input  logic               busReject,
  input  logic               aluCondTrue,
  input  logic [1:0]         condEffect,
  input  logic [COND_W-1:0]  aluCondCode,
  input  logic               iStackOvf,
  input  logic               eStackOvf,
  input  logic               pushPending,
  input  logic               popPending,
  input  logic               fetchFault,
  input  logic               reschedReq,
  input  logic [1:0]         reschedCtl,
  input  logic [1:0]         inhibitCtl,
  input  logic [1:0]         trapEffNow,
  input  logic [1:0]         trapEffPending,
  input  logic               cycDelayed,
  input  logic               cycleNextNonZero,
  output dp_ctl_t            dpCtl,
  output logic [3:0]         excState,
  output logic               killPipe,
  output logic               reschedPending,
  output logic               trapInhibit
);
  exc_e excQ, excD;
  logic killD, reschedD, inhibitD, reschedRaw, inhibitRaw, trapsEnabled;
  logic stickyHold;

  assign stickyHold = cycDelayed;

  always_comb begin
    reschedRaw = reschedReq || reschedCtl == CTL_SET ||
                 (reschedPending && reschedCtl != CTL_CLEAR);
    inhibitRaw = trapEffNow == TE_DISABLE || inhibitCtl == CTL_SET ||
                 (trapInhibit && inhibitCtl != CTL_CLEAR && trapEffNow != TE_ENABLE);
    trapsEnabled = trapEffPending == TE_ENABLE ||
                   (trapEffPending != TE_DISABLE && !inhibitRaw);
    excD = EXC_NONE;
    killD = 1'b0;
    reschedD = reschedRaw;
    inhibitD = inhibitRaw;
    dpCtl = '0;
    if (rstIn || excQ == EXC_PRE_RST) begin
      excD = rstIn ? EXC_PRE_RST : EXC_RST;
      killD = 1'b1; reschedD = 1'b0; inhibitD = 1'b1; dpCtl.clrCycle = 1'b1;
    end else if (busFault != '0) begin
      excD = EXC_BUS_FAULT; killD = 1'b1; inhibitD = 1'b1; dpCtl.clrCycle = 1'b1;
    end else if (aluCondTrue && condEffect == CE_MACRO_TRAP && !busReject) begin
      excD = EXC_COND_TRAP; killD = 1'b1; inhibitD = 1'b1; dpCtl.clrCycle = 1'b1;
    end else if (busReject) begin
      excD = EXC_BUS_REJECT;
    end else if (aluCondTrue && condEffect == CE_MACRO_JUMP) begin
      excD = EXC_JUMP_FLIP; killD = 1'b1; dpCtl.clrCycle = 1'b1;
    end else if (cycleNextNonZero) begin
      excD = EXC_NONE;
    end else if ((excQ == EXC_RESCHED && stickyHold) || (reschedRaw && trapsEnabled)) begin
      excD = EXC_RESCHED;
    end else if ((excQ == EXC_ISTK_OVF && stickyHold) ||
                 (iStackOvf && (pushPending || !popPending) && trapsEnabled)) begin
      excD = EXC_ISTK_OVF;
    end else if ((excQ == EXC_ESTK_OVF && stickyHold) || (eStackOvf && trapsEnabled)) begin
      excD = EXC_ESTK_OVF;
    end else if ((excQ == EXC_FETCH_FAULT && stickyHold) || fetchFault) begin
      excD = EXC_FETCH_FAULT;
    end

    unique case (excD)
      EXC_PRE_RST, EXC_RST: dpCtl.vecIndex = IDX_W'(IDX_RESET);
      EXC_BUS_FAULT: begin
        dpCtl.vecIndex  = IDX_W'(IDX_BUS0);
        dpCtl.vecOffset = IDX_W'(busFault);
      end
      EXC_COND_TRAP: begin
        dpCtl.vecIndex  = IDX_W'(IDX_COND0);
        dpCtl.vecOffset = IDX_W'(aluCondCode);
      end
      EXC_BUS_REJECT, EXC_JUMP_FLIP: dpCtl.vecZero = 1'b1;
      EXC_RESCHED:     dpCtl.vecIndex = IDX_W'(IDX_RESCHED);
      EXC_ISTK_OVF:    dpCtl.vecIndex = IDX_W'(IDX_ISTK);
      EXC_ESTK_OVF:    dpCtl.vecIndex = IDX_W'(IDX_ESTK);
      EXC_FETCH_FAULT: dpCtl.vecIndex = IDX_W'(IDX_FETCH);
      default:         dpCtl.vecIndex = IDX_W'(IDX_UNDERFLOW);
    endcase
  end

  always_ff @(posedge clk) begin
    excQ           <= excD;
    killPipe       <= killD;
    reschedPending <= reschedD;
    trapInhibit    <= inhibitD;
  end

  assign excState = excQ;
endmodule

// File: rtl/trap_exc_dp.sv
module trap_exc_dp
  import trap_exc_pkg::*;
#(
  parameter int CYC_W  = 6,
  parameter int ADDR_W = 16,
  parameter int BYTES_PER_WORD = 4,
  parameter int TRAP_BASE = 64,
  parameter int TRAP_WIDTH_WORDS = 4
) (
  input  logic              clk,
  input  logic              cycDone,
  input  logic              cycDelayed,
  input  logic              aluCondTrue,
  input  logic [1:0]        condEffect,
  input  dp_ctl_t           dpCtl,
  output logic              cycleNextNonZero,
  output logic [CYC_W-1:0]  cycleCount,
  output logic [ADDR_W-1:0] trapAddr
);
  localparam int SUM_W = IDX_W + 1;
  logic [CYC_W-1:0]  cycleRaw;
  logic [SUM_W-1:0]  vecSum;
  logic [ADDR_W-1:0] addrD;

  always_comb begin
    if (cycDone)                                          cycleRaw = '0;
    else if (cycDelayed)                                  cycleRaw = cycleCount;
    else if (aluCondTrue && condEffect == CE_MICRO_JUMP)  cycleRaw = cycleCount << 1;
    else                                                  cycleRaw = cycleCount + 1'b1;
  end

  assign cycleNextNonZero = cycleRaw != '0;
  assign vecSum = SUM_W'(dpCtl.vecIndex) + SUM_W'(dpCtl.vecOffset);
  assign addrD  = dpCtl.vecZero ? '0 :
                  ADDR_W'(BYTES_PER_WORD * (TRAP_BASE + TRAP_WIDTH_WORDS * int'(vecSum)));

  always_ff @(posedge clk) begin
    cycleCount <= dpCtl.clrCycle ? '0 : cycleRaw;
    trapAddr   <= addrD;
  end
endmodule

// File: rtl/trap_exception_unit.sv
module trap_exception_unit
  import trap_exc_pkg::*;
#(
  parameter int FAULT_W = 3,
  parameter int COND_W  = 4,
  parameter int CYC_W   = 6,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstIn,
  input  logic [FAULT_W-1:0] busFault,
  input  logic               busReject,
  input  logic               aluCondTrue,
  input  logic [1:0]         condEffect,
  input  logic [COND_W-1:0]  aluCondCode,
  input  logic               iStackOvf,
  input  logic               eStackOvf,
  input  logic               pushPending,
  input  logic               popPending,
  input  logic               fetchFault,
  input  logic               reschedReq,
  input  logic [1:0]         reschedCtl,
  input  logic [1:0]         inhibitCtl,
  input  logic [1:0]         trapEffNow,
  input  logic [1:0]         trapEffPending,
  input  logic               cycDone,
  input  logic               cycDelayed,
  output logic [3:0]         excState,
  output logic               killPipe,
  output logic [ADDR_W-1:0]  trapAddr,
  output logic [CYC_W-1:0]   cycleCount,
  output logic               reschedPending,
  output logic               trapInhibit
);
  dp_ctl_t dpCtl;
  logic    cycleNextNonZero;

  trap_exc_ctl #(.FAULT_W(FAULT_W), .COND_W(COND_W)) u_ctl (
    .clk(clk), .rstIn(rstIn), .busFault(busFault), .busReject(busReject),
    .aluCondTrue(aluCondTrue), .condEffect(condEffect), .aluCondCode(aluCondCode),
    .iStackOvf(iStackOvf), .eStackOvf(eStackOvf), .pushPending(pushPending),
    .popPending(popPending), .fetchFault(fetchFault), .reschedReq(reschedReq),
    .reschedCtl(reschedCtl), .inhibitCtl(inhibitCtl), .trapEffNow(trapEffNow),
    .trapEffPending(trapEffPending), .cycDelayed(cycDelayed),
    .cycleNextNonZero(cycleNextNonZero), .dpCtl(dpCtl), .excState(excState),
    .killPipe(killPipe), .reschedPending(reschedPending), .trapInhibit(trapInhibit)
  );

  trap_exc_dp #(.CYC_W(CYC_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .cycDone(cycDone), .cycDelayed(cycDelayed), .aluCondTrue(aluCondTrue),
    .condEffect(condEffect), .dpCtl(dpCtl), .cycleNextNonZero(cycleNextNonZero),
    .cycleCount(cycleCount), .trapAddr(trapAddr)
  );
endmodule

// File: rtl/trap_exception_unit_chk.sv
module trap_exception_unit_chk
  import trap_exc_pkg::*;
#(
  parameter int CYC_W  = 6,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstIn,
  input logic [1:0]        reschedCtl,
  input logic [1:0]        trapEffNow,
  input logic              cycDone,
  input logic              cycDelayed,
  input logic [3:0]        excState,
  input logic              killPipe,
  input logic [ADDR_W-1:0] trapAddr,
  input logic [CYC_W-1:0]  cycleCount,
  input logic              reschedPending,
  input logic              trapInhibit
);
  AST_RESET_SECOND_PHASE: assert property (@(posedge clk) disable iff (rstIn)
    excState == EXC_PRE_RST |=> excState == EXC_RST); // R2
  AST_KILL_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rstIn)
    killPipe |-> cycleCount == '0); // R3
  AST_ZERO_VECTOR: assert property (@(posedge clk) disable iff (rstIn)
    (excState == EXC_BUS_REJECT || excState == EXC_JUMP_FLIP) |-> trapAddr == '0); // R5
  AST_RESCHED_STICKY: assert property (@(posedge clk) disable iff (rstIn)
    (reschedPending && reschedCtl != CTL_CLEAR) |=> reschedPending); // R7
  AST_INHIBIT_ON_DISABLE: assert property (@(posedge clk) disable iff (rstIn)
    trapEffNow == TE_DISABLE |=> trapInhibit); // R8
  AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rstIn)
    (cycDelayed && !cycDone) |=> (killPipe || cycleCount == $past(cycleCount))); // R6
endmodule

bind trap_exception_unit trap_exception_unit_chk #(.CYC_W(CYC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstIn(rstIn), .reschedCtl(reschedCtl), .trapEffNow(trapEffNow),
  .cycDone(cycDone), .cycDelayed(cycDelayed), .excState(excState),
  .killPipe(killPipe), .trapAddr(trapAddr), .cycleCount(cycleCount),
  .reschedPending(reschedPending), .trapInhibit(trapInhibit)
);

// File: tb/trap_exception_unit_bench.sv
module trap_exception_unit_bench;
  localparam int FW = 3, CW = 4, YW = 6, AW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstIn, busReject, aluCondTrue, iStackOvf, eStackOvf, pushPending, popPending;
  logic fetchFault, reschedReq, cycDone, cycDelayed;
  logic [FW-1:0] busFault;
  logic [CW-1:0] aluCondCode;
  logic [1:0] condEffect, reschedCtl, inhibitCtl, trapEffNow, trapEffPending;
  logic [3:0] excState;
  logic killPipe, reschedPending, trapInhibit;
  logic [AW-1:0] trapAddr;
  logic [YW-1:0] cycleCount;

  trap_exception_unit u_trap_exception_unit (
    .clk(clk), .rstIn(rstIn), .busFault(busFault), .busReject(busReject),
    .aluCondTrue(aluCondTrue), .condEffect(condEffect), .aluCondCode(aluCondCode),
    .iStackOvf(iStackOvf), .eStackOvf(eStackOvf), .pushPending(pushPending),
    .popPending(popPending), .fetchFault(fetchFault), .reschedReq(reschedReq),
    .reschedCtl(reschedCtl), .inhibitCtl(inhibitCtl), .trapEffNow(trapEffNow),
    .trapEffPending(trapEffPending), .cycDone(cycDone), .cycDelayed(cycDelayed),
    .excState(excState), .killPipe(killPipe), .trapAddr(trapAddr),
    .cycleCount(cycleCount), .reschedPending(reschedPending), .trapInhibit(trapInhibit)
  );

  int errors = 0, checks = 0;
  int mExc = 0, mCyc = 0;
  bit mRes = 0, mInh = 0, mKill = 0;
  int mAddr = 0;

  function automatic int vecAddr(int idx);
    return 4 * (64 + 4 * idx);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic quiet();
    rstIn = 0; busFault = 0; busReject = 0; aluCondTrue = 0; condEffect = 0;
    aluCondCode = 0; iStackOvf = 0; eStackOvf = 0; pushPending = 0; popPending = 0;
    fetchFault = 0; reschedReq = 0; reschedCtl = 0; inhibitCtl = 0;
    trapEffNow = 0; trapEffPending = 0; cycDone = 1; cycDelayed = 0;
  endtask

  // reference model of one clock, from the requirements
  task automatic model();
    int raw, e, idx;
    bit nRes, nInh, en, kill, clr;
    if (cycDone) raw = 0;
    else if (cycDelayed) raw = mCyc;
    else if (aluCondTrue && condEffect == 1) raw = (mCyc * 2) % 64;
    else raw = (mCyc + 1) % 64;
    nRes = reschedReq || reschedCtl == 1 || (mRes && reschedCtl != 2);
    nInh = trapEffNow == 2 || inhibitCtl == 1 || (mInh && inhibitCtl != 2 && trapEffNow != 1);
    en = trapEffPending == 1 || (trapEffPending != 2 && !nInh);
    kill = 0; clr = 0;
    if (rstIn || mExc == 1) begin
      e = rstIn ? 1 : 2; kill = 1; clr = 1; nRes = 0; nInh = 1;
    end else if (busFault != 0) begin e = 3; kill = 1; clr = 1; nInh = 1; end
    else if (aluCondTrue && condEffect == 2 && !busReject) begin e = 4; kill = 1; clr = 1; nInh = 1; end
    else if (busReject) e = 5;
    else if (aluCondTrue && condEffect == 3) begin e = 6; kill = 1; clr = 1; end
    else if (raw != 0) e = 0;
    else if ((mExc == 7 && cycDelayed) || (nRes && en)) e = 7;
    else if ((mExc == 8 && cycDelayed) || (iStackOvf && (pushPending || !popPending) && en)) e = 8;
    else if ((mExc == 9 && cycDelayed) || (eStackOvf && en)) e = 9;
    else if ((mExc == 10 && cycDelayed) || fetchFault) e = 10;
    else e = 0;
    case (e)
      1, 2: idx = 2;
      3: idx = 8 + int'(busFault);
      4: idx = 16 + int'(aluCondCode);
      7: idx = 3; 8: idx = 4; 9: idx = 5; 10: idx = 6;
      default: idx = 1;
    endcase
    mAddr = (e == 5 || e == 6) ? 0 : vecAddr(idx);
    mExc = e; mKill = kill; mCyc = clr ? 0 : raw; mRes = nRes; mInh = nInh;
  endtask

  // inputs already driven at a negedge; clock once and compare
  task automatic step(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    check(tag, "excState", int'(excState), mExc);
    check(tag, "killPipe", int'(killPipe), int'(mKill));
    check(tag, "trapAddr", int'(trapAddr), mAddr);
    check(tag, "cycleCount", int'(cycleCount), mCyc);
    check(tag, "reschedPending", int'(reschedPending), int'(mRes));
    check(tag, "trapInhibit", int'(trapInhibit), int'(mInh));
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    quiet(); rstIn = 1;
    repeat (3) @(negedge clk);
    step("R2");                             // about-to-reset phase
    check("R2", "reset vector", int'(trapAddr), 272 + 4 * 4);
    quiet(); step("R2");                    // reset phase after release
    check("R2", "second phase code", int'(excState), 2);
    quiet(); step("R11");                   // idle: underflow vector
    check("R11", "underflow addr", int'(trapAddr), 272);
    quiet(); busFault = 5; aluCondTrue = 1; condEffect = 2; step("R3");
    check("R4", "bus fault vector", int'(trapAddr), vecAddr(13));
    quiet(); aluCondTrue = 1; condEffect = 2; aluCondCode = 7; step("R4");
    quiet(); aluCondTrue = 1; condEffect = 2; busReject = 1; cycDone = 0; step("R1");
    check("R5", "reject vector zero", int'(trapAddr), 0);
    quiet(); aluCondTrue = 1; condEffect = 3; step("R5");
    // counter: count up, double, stall
    quiet(); cycDone = 0; step("R6"); step("R6"); step("R6");
    aluCondTrue = 1; condEffect = 1; step("R6");
    quiet(); cycDone = 0; cycDelayed = 1; step("R6");
    quiet(); step("R6");
    // reschedule flag
    quiet(); reschedReq = 1; step("R7");
    quiet(); step("R7");
    quiet(); reschedCtl = 2; step("R7");
    // inhibit and enable
    quiet(); inhibitCtl = 2; step("R8");
    quiet(); trapEffNow = 2; step("R8");
    quiet(); eStackOvf = 1; step("R9");     // inhibited: not taken
    quiet(); eStackOvf = 1; trapEffPending = 1; step("R9");
    quiet(); trapEffNow = 1; step("R8");
    quiet(); iStackOvf = 1; popPending = 1; step("R9");   // pop only: skipped
    quiet(); iStackOvf = 1; popPending = 1; pushPending = 1; step("R9");
    quiet(); fetchFault = 1; step("R10");
    quiet(); cycDelayed = 1; step("R10");   // held through stall
    quiet(); step("R10");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      quiet();
      rstIn = ($urandom % 64) == 0;
      busFault = (($urandom % 10) == 0) ? FW'($urandom) : '0;
      busReject = ($urandom % 10) == 0;
      aluCondTrue = $urandom % 2;
      condEffect = 2'($urandom % 6 < 4 ? 0 : $urandom);
      aluCondCode = CW'($urandom);
      iStackOvf = ($urandom % 6) == 0; eStackOvf = ($urandom % 6) == 0;
      pushPending = $urandom % 2; popPending = $urandom % 2;
      fetchFault = ($urandom % 8) == 0; reschedReq = ($urandom % 12) == 0;
      reschedCtl = 2'($urandom % 4); inhibitCtl = 2'($urandom % 4);
      trapEffNow = 2'($urandom % 3); trapEffPending = 2'($urandom % 3);
      cycDone = ($urandom % 3) != 0; cycDelayed = ($urandom % 4) == 0;
      step("R1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule